// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller

This block drives a 64K x 1 dynamic memory that is organised as a 256 x 256 cell array and reached over one shared 8-bit address bus. A host hands it read or write requests with a 16-bit address over a valid/ready handshake. The controller opens the row, accesses one or more columns of that row, and then writes the whole row back. Opening a row empties its cells, so the write-back is required. Read data comes back one bit per accessed column, each bit marked by a single-cycle valid pulse.

The cell array and the row buffer are modelled inside the block as synthesizable storage, so the block can be simulated and built on its own. A background timer requests a refresh of one row per interval. It walks all rows in order, and each refresh is a complete open and write-back cycle with no column access. Phase lengths are parameters counted in clock cycles. At the defaults and a 200 MHz clock they give a 50 ns row phase, a 10 ns first column phase, a 25 ns page-mode column phase and a 30 ns write-back phase.

Top module: `mux_dram_ctrl`

## Requirements
- R1: After reset, `ras_act`, `cas_act` and `rd_valid` are low and `req_ready` is high.
- R2: While a row is being opened, `dram_addr` carries `req_addr[15:8]`, and it holds that value through the row phase. While `cas_act` is high, `dram_addr` carries the column of the current beat. `cas_act` is only ever high while `ras_act` is high.
- R3: A read returns the stored bit of each accessed column on `rd_data`. One `rd_valid` pulse is given per beat, in the cycle after that beat's column phase ends.
- R4: A write stores `req_wdata[k]` into beat k's column. The stored data survives later accesses to the same row and to other rows.
- R5: A single-beat access keeps `ras_act` high for exactly T_RAS+T_CAS+T_WB cycles, and `cas_act` high for T_CAS of those cycles.
- R6: Page mode: `req_len` holds the beat count minus one. A burst of n beats touches columns col, col+1, ..., col+n-1, which wrap modulo 256 inside the row. `ras_act` stays high for T_RAS+T_CAS+(n-1)*T_PAGE+T_WB cycles, and `cas_act` stays high for T_CAS+(n-1)*T_PAGE of them.
- R7: Every REF_INTERVAL cycles a refresh becomes due. A refresh raises `ras_act` for T_RAS+T_WB cycles with `cas_act` low. Its row, shown on `dram_addr`, starts at 0 after reset and increases by one per refresh, wrapping from 255 to 0.
- R8: Data written before a complete refresh sweep of all 256 rows reads back unchanged after the sweep.
- R9: A refresh that becomes due during an access waits until that row's write-back ends. It is then started before any waiting host request, so two refresh starts are never more than REF_INTERVAL plus one longest access apart.
- R10: `req_ready` is low whenever `ras_act` is high. A request is taken only in a cycle where `req_valid` and `req_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and no refresh due |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Row in [15:8], starting column in [7:0] |
| req_len | input | 3 | Beats minus one (page-mode burst) |
| req_wdata | input | 8 | Write bit for beat k in bit k |
| rd_valid | output | 1 | Read bit valid, one pulse per beat |
| rd_data | output | 1 | Read bit |
| dram_addr | output | 8 | Shared row/column address lines |
| ras_act | output | 1 | Row strobe, high while a row is open |
| cas_act | output | 1 | Column strobe |

## Verification
A wrong phase counter shows up at the ports within one access, because the `ras_act` and `cas_act` windows get the wrong length. A wrong column pointer puts a wrong value on `dram_addr` in the first cycle of the affected beat. A lost or skipped write-back leaves the row emptied, and this appears as wrong `rd_data` on the next read of that row, whether or not a refresh has passed over it. A refresh pointer or priority fault appears at the next refresh pulse, as a wrong row number or as a gap between refreshes that is too long.

// File: rtl/mdc_pkg.sv
package mdc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RAS, ST_CAS, ST_PAGE, ST_WB, ST_REF
  } mdc_state_e;
endpackage

// File: rtl/mdc_refresh_sched.sv
module mdc_refresh_sched #(
  parameter int ROW_BITS = 8,
  parameter int INTERVAL = 781
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ack,
  output logic                pending,
  output logic [ROW_BITS-1:0] row
);
  localparam int IW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;

  logic [IW-1:0] tick_cnt;
  logic          wrap;

  assign wrap = (tick_cnt == IW'(INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_cnt <= '0;
      pending  <= 1'b0;
      row      <= '0;
    end else begin
      tick_cnt <= wrap ? '0 : tick_cnt + 1'b1;
      if (wrap)
        pending <= 1'b1;
      else if (ack)
        pending <= 1'b0;
      if (ack)
        row <= row + 1'b1;
    end
  end
endmodule

// File: rtl/mdc_cell_array.sv
module mdc_cell_array #(
  parameter int ROW_BITS = 8,
  parameter int COLS     = 256
) (
  input  logic                clk,
  input  logic                we,
  input  logic [ROW_BITS-1:0] row,
  input  logic [COLS-1:0]     wdata,
  output logic [COLS-1:0]     rdata
);
  localparam int ROWS = 2 ** ROW_BITS;

  logic [COLS-1:0] cells [ROWS];

  // read-first single-port storage, one row per word
  always_ff @(posedge clk) begin
    if (we)
      cells[row] <= wdata;
    rdata <= cells[row];
  end
endmodule

// File: rtl/mdc_sequencer.sv
module mdc_sequencer
  import mdc_pkg::*;
#(
  parameter int ROW_BITS  = 8,
  parameter int COL_BITS  = 8,
  parameter int BURST_MAX = 8,
  parameter int T_RAS     = 10,
  parameter int T_CAS     = 2,
  parameter int T_PAGE    = 5,
  parameter int T_WB      = 6
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_write,
  input  logic [ROW_BITS+COL_BITS-1:0]  req_addr,
  input  logic [$clog2(BURST_MAX)-1:0]  req_len,
  input  logic [BURST_MAX-1:0]          req_wdata,
  input  logic                          ref_pending,
  input  logic [ROW_BITS-1:0]           ref_row,
  output logic                          ref_ack,
  input  logic [(2**COL_BITS)-1:0]      arr_rdata,
  output logic                          arr_we,
  output logic [(2**COL_BITS)-1:0]      arr_wdata,
  output logic [ROW_BITS-1:0]           arr_row,
  output logic                          rd_valid,
  output logic                          rd_data,
  output logic [((ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS)-1:0] dram_addr,
  output mdc_state_e                    state_o
);
  localparam int ADDR_W = ROW_BITS + COL_BITS;
  localparam int COLS   = 2 ** COL_BITS;
  localparam int LEN_W  = $clog2(BURST_MAX);
  localparam int MUX_W  = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS;
  localparam int TM1    = (T_RAS > T_CAS) ? T_RAS : T_CAS;
  localparam int TM2    = (T_PAGE > T_WB) ? T_PAGE : T_WB;
  localparam int TMAX   = (TM1 > TM2) ? TM1 : TM2;
  localparam int CW     = $clog2(TMAX + 1);

  mdc_state_e          state;
  logic [CW-1:0]       cnt;
  logic [ROW_BITS-1:0] cur_row;
  logic [COL_BITS-1:0] cur_col;
  logic [LEN_W-1:0]    beats_left;
  logic [LEN_W-1:0]    beat;
  logic                is_wr;
  logic [BURST_MAX-1:0] wbits;
  logic [COLS-1:0]     rowbuf;
  logic                phase_end;

  assign phase_end = (cnt == '0);
  assign state_o   = state;
  assign req_ready = (state == ST_IDLE) && !ref_pending;
  assign ref_ack   = (state == ST_IDLE) && ref_pending;
  assign arr_row   = cur_row;
  // opening empties the row; write-back restores the buffer
  assign arr_we    = phase_end && (state == ST_RAS || state == ST_REF || state == ST_WB);
  assign arr_wdata = (state == ST_WB) ? rowbuf : '0;

  always_comb begin
    case (state)
      ST_RAS, ST_REF, ST_WB: dram_addr = MUX_W'(cur_row);
      ST_CAS, ST_PAGE:       dram_addr = MUX_W'(cur_col);
      default:               dram_addr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      cur_row    <= '0;
      cur_col    <= '0;
      beats_left <= '0;
      beat       <= '0;
      is_wr      <= 1'b0;
      wbits      <= '0;
      rowbuf     <= '0;
      rd_valid   <= 1'b0;
      rd_data    <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      if (state != ST_IDLE && !phase_end) begin
        cnt <= cnt - 1'b1;
      end else begin
        case (state)
          ST_IDLE: begin
            if (ref_pending) begin
              state   <= ST_REF;
              cnt     <= CW'(T_RAS - 1);
              cur_row <= ref_row;
            end else if (req_valid) begin
              state      <= ST_RAS;
              cnt        <= CW'(T_RAS - 1);
              cur_row    <= req_addr[ADDR_W-1:COL_BITS];
              cur_col    <= req_addr[COL_BITS-1:0];
              beats_left <= req_len;
              beat       <= '0;
              is_wr      <= req_write;
              wbits      <= req_wdata;
            end
          end
          ST_RAS: begin
            rowbuf <= arr_rdata;
            state  <= ST_CAS;
            cnt    <= CW'(T_CAS - 1);
          end
          ST_REF: begin
            rowbuf <= arr_rdata;
            state  <= ST_WB;
            cnt    <= CW'(T_WB - 1);
          end
          ST_CAS, ST_PAGE: begin
            if (is_wr) begin
              rowbuf[cur_col] <= wbits[beat];
            end else begin
              rd_data  <= rowbuf[cur_col];
              rd_valid <= 1'b1;
            end
            if (beats_left != '0) begin
              state      <= ST_PAGE;
              cnt        <= CW'(T_PAGE - 1);
              cur_col    <= cur_col + 1'b1;
              beat       <= beat + 1'b1;
              beats_left <= beats_left - 1'b1;
            end else begin
              state <= ST_WB;
              cnt   <= CW'(T_WB - 1);
            end
          end
          ST_WB: begin
            state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mux_dram_ctrl.sv
module mux_dram_ctrl
  import mdc_pkg::*;
#(
  parameter int ROW_BITS     = 8,
  parameter int COL_BITS     = 8,
  parameter int BURST_MAX    = 8,
  parameter int T_RAS        = 10,
  parameter int T_CAS        = 2,
  parameter int T_PAGE       = 5,
  parameter int T_WB         = 6,
  parameter int REF_INTERVAL = 781,
  localparam int ADDR_W      = ROW_BITS + COL_BITS,
  localparam int LEN_W       = $clog2(BURST_MAX),
  localparam int MUX_W       = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [BURST_MAX-1:0] req_wdata,
  output logic              rd_valid,
  output logic              rd_data,
  output logic [MUX_W-1:0]  dram_addr,
  output logic              ras_act,
  output logic              cas_act
);
  localparam int COLS = 2 ** COL_BITS;

  logic                ref_pending;
  logic                ref_ack;
  logic [ROW_BITS-1:0] ref_row;
  logic                arr_we;
  logic [ROW_BITS-1:0] arr_row;
  logic [COLS-1:0]     arr_wdata;
  logic [COLS-1:0]     arr_rdata;
  mdc_state_e          seq_state;

  assign ras_act = (seq_state != ST_IDLE);
  assign cas_act = (seq_state == ST_CAS) || (seq_state == ST_PAGE);

  mdc_refresh_sched #(.ROW_BITS(ROW_BITS), .INTERVAL(REF_INTERVAL)) u_ref (
    .clk(clk), .rst(rst), .ack(ref_ack), .pending(ref_pending), .row(ref_row)
  );

  mdc_cell_array #(.ROW_BITS(ROW_BITS), .COLS(COLS)) u_arr (
    .clk(clk), .we(arr_we), .row(arr_row), .wdata(arr_wdata), .rdata(arr_rdata)
  );

  mdc_sequencer #(
    .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .BURST_MAX(BURST_MAX),
    .T_RAS(T_RAS), .T_CAS(T_CAS), .T_PAGE(T_PAGE), .T_WB(T_WB)
  ) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .ref_pending(ref_pending), .ref_row(ref_row), .ref_ack(ref_ack),
    .arr_rdata(arr_rdata), .arr_we(arr_we), .arr_wdata(arr_wdata), .arr_row(arr_row),
    .rd_valid(rd_valid), .rd_data(rd_data), .dram_addr(dram_addr), .state_o(seq_state)
  );
endmodule

// File: rtl/mdc_checker.sv
module mdc_checker
  import mdc_pkg::*;
#(
  parameter int MW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          req_ready,
  input logic          rd_valid,
  input logic          ras_act,
  input logic          cas_act,
  input logic [MW-1:0] dram_addr,
  input logic          ref_pending,
  input mdc_state_e    seq_state
);
  // R2
  cas_inside_ras_chk: assert property (@(posedge clk) disable iff (rst)
    cas_act |-> ras_act);

  // R2
  row_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ras_act) |=> $stable(dram_addr));

  // R3
  rd_after_cas_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(cas_act));

  // R10
  no_accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    ras_act |-> !req_ready);

  // R9
  refresh_first_chk: assert property (@(posedge clk) disable iff (rst)
    (ref_pending && seq_state == ST_IDLE) |=> (seq_state == ST_REF));

  // R7
  refresh_no_cas_chk: assert property (@(posedge clk) disable iff (rst)
    (seq_state == ST_REF || (seq_state == ST_WB && $past(seq_state) == ST_REF)) |-> !cas_act);
endmodule

bind mux_dram_ctrl mdc_checker #(.MW(MUX_W)) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .rd_valid(rd_valid),
  .ras_act(ras_act), .cas_act(cas_act), .dram_addr(dram_addr),
  .ref_pending(ref_pending), .seq_state(seq_state)
);

// File: tb/mux_dram_ctrl_test.sv
`timescale 1ns/1ps
module mux_dram_ctrl_test;
  localparam int T_RAS = 10, T_CAS = 2, T_PAGE = 5, T_WB = 6;
  localparam int INTERVAL = 100;
  localparam int MAXACC = T_RAS + T_CAS + 7 * T_PAGE + T_WB;

  logic clk = 0;
  logic rst = 1;
  logic req_valid = 0, req_write = 0;
  logic [15:0] req_addr = '0;
  logic [2:0] req_len = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rd_valid, rd_data, ras_act, cas_act;
  logic [7:0] dram_addr;

  always #2.5 clk = ~clk;

  mux_dram_ctrl #(.T_RAS(T_RAS), .T_CAS(T_CAS), .T_PAGE(T_PAGE), .T_WB(T_WB),
                  .REF_INTERVAL(INTERVAL)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
    .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .dram_addr(dram_addr), .ras_act(ras_act), .cas_act(cas_act));

  int checks = 0, errors = 0;
  int cyc = 0;
  logic [255:0] sh_val [256];
  logic [255:0] sh_kn  [256];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int exp_ras(input int n);
    return T_RAS + T_CAS + (n - 1) * T_PAGE + T_WB;
  endfunction
  function automatic int exp_cas(input int n);
    return T_CAS + (n - 1) * T_PAGE;
  endfunction

  // refresh pulse monitor (R7, R9)
  logic prev_ras = 0;
  int p_len = 0, ref_count = 0, last_ref_start = -1, p_start = 0;
  bit p_cas = 0;
  logic [7:0] p_row = 0, ref_exp = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (ras_act && !prev_ras) begin
        p_len = 1; p_cas = cas_act; p_row = dram_addr; p_start = cyc;
      end else if (ras_act) begin
        p_len++; p_cas = p_cas | cas_act;
      end else if (prev_ras && !p_cas) begin
        chk(p_len == T_RAS + T_WB, "R7 refresh length", p_len, T_RAS + T_WB);
        chk(p_row == ref_exp, "R7 refresh row", p_row, ref_exp);
        if (last_ref_start >= 0)
          chk(p_start - last_ref_start <= INTERVAL + MAXACC + 2, "R9 refresh gap",
              p_start - last_ref_start, INTERVAL + MAXACC + 2);
        last_ref_start = p_start;
        ref_exp = ref_exp + 8'd1;
        ref_count++;
      end
      prev_ras = ras_act;
    end
  end

  // one host transaction; called and returning at a falling edge
  task automatic txn(input bit wr, input logic [15:0] a, input int n, input logic [7:0] wb);
    int ras_c, cas_c, rk, bt;
    logic [7:0] row, col, ec;
    row = a[15:8]; col = a[7:0];
    req_valid = 1; req_write = wr; req_addr = a; req_len = 3'(n - 1); req_wdata = wb;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 0;
    ras_c = 0; cas_c = 0; rk = 0;
    @(negedge clk);
    while (ras_act) begin
      if (ras_c == 0) begin
        chk(dram_addr == row, "R2 row address", dram_addr, row);
        chk(req_ready == 0, "R10 ready low while busy", req_ready, 0);
      end
      if (cas_act) begin
        bt = (cas_c < T_CAS) ? 0 : 1 + (cas_c - T_CAS) / T_PAGE;
        if (cas_c == 0 || (cas_c >= T_CAS && (cas_c - T_CAS) % T_PAGE == 0)) begin
          ec = col + 8'(bt);
          chk(dram_addr == ec, "R6 column address", dram_addr, ec);
        end
        cas_c++;
      end
      if (rd_valid) begin
        ec = col + 8'(rk);
        if (wr) chk(0, "R3 rd_valid on write", 1, 0);
        else if (sh_kn[row][ec]) chk(rd_data == sh_val[row][ec], "R3 read data", rd_data, sh_val[row][ec]);
        rk++;
      end
      ras_c++;
      @(negedge clk);
    end
    chk(ras_c == exp_ras(n), (n == 1) ? "R5 ras window" : "R6 ras window", ras_c, exp_ras(n));
    chk(cas_c == exp_cas(n), (n == 1) ? "R5 cas window" : "R6 cas window", cas_c, exp_cas(n));
    if (!wr) chk(rk == n, "R3 beat count", rk, n);
    if (wr)
      for (int k = 0; k < n; k++) begin
        ec = col + 8'(k);
        sh_val[row][ec] = wb[k];
        sh_kn[row][ec]  = 1'b1;
      end
  endtask

  initial begin
    int seed, r;
    seed = $urandom(32'd1357);
    for (int i = 0; i < 256; i++) begin sh_val[i] = '0; sh_kn[i] = '0; end
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 0;
    chk(ras_act == 0 && cas_act == 0, "R1 strobes idle", {ras_act, cas_act}, 0);
    chk(rd_valid == 0, "R1 rd_valid low", rd_valid, 0);
    chk(req_ready == 1, "R1 ready high", req_ready, 1);

    // directed: single writes then a two-beat read (R3, R4)
    txn(1, 16'h1234, 1, 8'h01);
    txn(1, 16'h1235, 1, 8'h00);
    txn(0, 16'h1234, 2, 8'h00);
    // page burst wrapping past column 255 (R6)
    txn(1, 16'h34FC, 8, 8'hA5);
    txn(0, 16'h34FC, 8, 8'h00);
    // other row in between, then revisit (R4)
    txn(1, 16'h3500, 8, 8'hFF);
    txn(0, 16'h34FC, 8, 8'h00);
    txn(0, 16'h1234, 1, 8'h00);

    // random traffic over a set of rows
    for (int i = 0; i < 250; i++) begin
      logic [15:0] a;
      a = {8'(($urandom % 16) * 16 + 3), 8'($urandom)};
      r = $urandom;
      txn(r[0], a, 1 + ($urandom % 8), 8'($urandom));
    end

    // let a full refresh sweep pass with no host traffic (R7, R8)
    repeat (27000) @(negedge clk);
    chk(ref_count > 256, "R7 refresh pointer wrapped", ref_count, 257);
    chk(ref_count >= cyc / INTERVAL - 1, "R9 refresh not starved", ref_count, cyc / INTERVAL - 1);
    for (int i = 0; i < 40; i++) begin
      logic [15:0] a;
      a = {8'(($urandom % 16) * 16 + 3), 8'($urandom)};
      txn(0, a, 8, 8'h00);   // R8 read-back after sweep
    end
    txn(0, 16'h34FC, 8, 8'h00); // R8
    txn(0, 16'h1234, 2, 8'h00); // R8

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cyc > 190000);
    checks++; errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 190000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule